// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between a writer running on one clock and a reader running on another. It keeps the words in an internal two-port memory. Each side sees only flags made in its own clock domain. The writer gets full and almost-full. The reader gets empty and almost-empty. All four flags are active low. The pointers cross between domains as Gray code through a synchronizer chain. A flag can therefore be released a few cycles late, but it is never raised late.

One write-side pin is strapped by its level while reset is held, and it keeps that meaning until the next reset:
- **High at reset (two-enable mode):** the pin is a second, active-high write enable.
- **Low at reset (load mode):** the pin is a load strobe. With the strobe low, writes go to the two threshold registers and reads return them, alternating between them. With the strobe high, ordinary data writes need only the first enable.

The read data bus floats whenever the output enable is high.

The flags act as the stream back-pressure:
- `full_n` low is "not ready" to the writer, and a write attempted then is discarded.
- `empty_n` low is "not valid" to the reader, and a read attempted then is discarded.
- The almost flags give early warning, with a margin set by the threshold registers.

Top module: `dcf_fifo`

## Requirements
- R1: Words leave in the order they were accepted. `rd_data` takes the new word at the read-clock edge that accepts the read and holds it otherwise.
- R2: While `rst_n` is low, both pointers clear, `empty_n` and `aempty_n` are low, and `full_n` and `afull_n` are high.
- R3: The level of `wr_en2_ld` while reset is held picks the mode: high selects two-enable mode, low selects load mode. The mode does not change until the next reset.
- R4: A write is accepted at a write-clock edge only while `full_n` is high. A write attempted while full changes no stored word and no pointer.
- R5: In two-enable mode a write needs `wr_en1_n` low and `wr_en2_ld` high at the same edge. With `wr_en2_ld` low nothing is stored.
- R6: In load mode, `wr_en1_n` low with `wr_en2_ld` high writes data. `wr_en1_n` low with `wr_en2_ld` low stores `wr_data` into a threshold register instead of the FIFO. The first such write goes to the almost-empty threshold, the next to the almost-full threshold, and the order then repeats.
- R7: A read is accepted at a read-clock edge only when `rd_en1_n` and `rd_en2_n` are both low and `empty_n` is high. Any other read attempt leaves the pointer and `rd_data` unchanged.
- R8: A write that fills the FIFO drives `full_n` low from that same write-clock edge. A read that takes the last word drives `empty_n` low from that same read-clock edge.
- R9: Let N be the stored word count. `aempty_n` is low when N <= almost-empty threshold. `afull_n` is low when DEPTH - N <= almost-full threshold. Reset loads both thresholds with 7.
- R10: `rd_data` is high-impedance while `oe_n` is high and drives the read register while `oe_n` is low.
- R11: In load mode, `rd_en1_n` and `rd_en2_n` both low with `wr_en2_ld` low loads a threshold onto `rd_data` in the order of R6: almost-empty first, then almost-full, repeating. The FIFO read pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides, also the mode strap window |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (high) or threshold load strobe (low), chosen at reset |
| wr_data | input | 9 | Write data or threshold value |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable for rd_data, active low |
| rd_data | output | 9 | Read data, high-impedance when oe_n is high |
| empty_n | output | 1 | Empty flag, low when empty, read-clock domain |
| aempty_n | output | 1 | Almost-empty flag, read-clock domain |
| full_n | output | 1 | Full flag, low when full, write-clock domain |
| afull_n | output | 1 | Almost-full flag, write-clock domain |

## Verification
The bench builds the block with DEPTH set to 16 and keeps the thresholds at their default of 7. At that depth the almost-full point (9 words), the full point and a full pointer wrap are reached within a few dozen writes. The two clocks run at the same rate with a fixed phase offset, so flag release crosses a real asynchronous boundary. In load mode the thresholds are reprogrammed to 3 and 2 so that both almost flags move to new, non-default counts.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {MODE_DUAL_WEN = 1'b0, MODE_LOAD = 1'b1} dcf_mode_e;
  typedef enum logic {OFS_AE = 1'b0, OFS_AF = 1'b1} dcf_ofs_e;

  function automatic dcf_ofs_e ofs_next(dcf_ofs_e s);
    return (s == OFS_AE) ? OFS_AF : OFS_AE;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side import dcf_pkg::*; #(
  parameter int DATA_W     = 9,
  parameter int DEPTH      = 256,
  parameter int ADDR_W     = 8,
  parameter int AE_DEFAULT = 7,
  parameter int AF_DEFAULT = 7
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic [ADDR_W-1:0] waddr,
  output logic              mem_we,
  output logic [ADDR_W:0]   wgray,
  output logic              full_n,
  output logic              afull_n,
  output logic [DATA_W-1:0] ae_off,
  output logic [DATA_W-1:0] af_off
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int CMP_W = ((PTR_W > DATA_W) ? PTR_W : DATA_W) + 1;

  dcf_mode_e         mode_q;
  dcf_ofs_e          sel_q;
  logic [PTR_W-1:0]  wbin_q, wbin_nxt, rbin;
  logic [PTR_W-1:0]  wgray_q;
  logic [DATA_W-1:0] ae_q, af_q;
  logic [CMP_W-1:0]  used_w, free_w;
  logic              data_wr, ofs_wr;

  // Mode strap: captured on every write-clock edge while reset is held.
  always_ff @(posedge wclk) begin
    if (!rst_n) mode_q <= wen2_ld ? MODE_DUAL_WEN : MODE_LOAD;
  end

  always_comb begin
    for (int i = 0; i < PTR_W; i++) rbin[i] = ^(rgray_sync >> i);
  end

  assign used_w   = CMP_W'(wbin_q - rbin);
  assign free_w   = CMP_W'(DEPTH) - used_w;
  assign full_n   = (used_w != CMP_W'(DEPTH));
  assign afull_n  = !(free_w <= CMP_W'(af_q));
  assign data_wr  = full_n && !wen1_n && wen2_ld;
  assign ofs_wr   = (mode_q == MODE_LOAD) && !wen1_n && !wen2_ld;
  assign wbin_nxt = wbin_q + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      sel_q   <= OFS_AE;
      ae_q    <= DATA_W'(AE_DEFAULT);
      af_q    <= DATA_W'(AF_DEFAULT);
    end else begin
      if (data_wr) begin
        wbin_q  <= wbin_nxt;
        wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      if (ofs_wr) begin
        if (sel_q == OFS_AE) ae_q <= wdata;
        else                 af_q <= wdata;
        sel_q <= ofs_next(sel_q);
      end
    end
  end

  assign waddr  = wbin_q[ADDR_W-1:0];
  assign mem_we = data_wr;
  assign wgray  = wgray_q;
  assign ae_off = ae_q;
  assign af_off = af_q;

  p_no_overflow_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin_q));
  p_single_step_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> (wbin_q == $past(wbin_q)) || (wbin_q == $past(wbin_q) + 1'b1));
  p_gray_one_bit_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> $countones(wgray_q ^ $past(wgray_q)) <= 1);
  p_full_implies_afull_r9: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  p_mode_hold_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side import dcf_pkg::*; #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              ld_pin,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [DATA_W-1:0] ae_off,
  input  logic [DATA_W-1:0] af_off,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic [DATA_W-1:0] q,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int CMP_W = ((PTR_W > DATA_W) ? PTR_W : DATA_W) + 1;

  dcf_mode_e         mode_q;
  dcf_ofs_e          sel_q;
  logic [PTR_W-1:0]  rbin_q, rbin_nxt, wbin;
  logic [PTR_W-1:0]  rgray_q;
  logic [DATA_W-1:0] q_q;
  logic [CMP_W-1:0]  used_r;
  logic              both_en, data_rd, ofs_rd;

  // Mode strap: captured on every read-clock edge while reset is held.
  always_ff @(posedge rclk) begin
    if (!rst_n) mode_q <= ld_pin ? MODE_DUAL_WEN : MODE_LOAD;
  end

  always_comb begin
    for (int i = 0; i < PTR_W; i++) wbin[i] = ^(wgray_sync >> i);
  end

  assign used_r   = CMP_W'(wbin - rbin_q);
  assign empty_n  = (used_r != '0);
  assign aempty_n = !(used_r <= CMP_W'(ae_off));
  assign both_en  = !ren1_n && !ren2_n;
  assign ofs_rd   = (mode_q == MODE_LOAD) && !ld_pin && both_en;
  assign data_rd  = empty_n && both_en && !ofs_rd;
  assign rbin_nxt = rbin_q + 1'b1;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
      sel_q   <= OFS_AE;
    end else if (ofs_rd) begin
      q_q   <= (sel_q == OFS_AE) ? ae_off : af_off;
      sel_q <= ofs_next(sel_q);
    end else if (data_rd) begin
      q_q     <= mem_rdata;
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign raddr = rbin_q[ADDR_W-1:0];
  assign rgray = rgray_q;
  assign q     = q_q;

  p_no_underflow_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin_q));
  p_hold_without_enables_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(q_q) && $stable(rbin_q));
  p_offset_read_no_move_r11: assert property (@(posedge rclk) disable iff (!rst_n)
    ofs_rd |=> $stable(rbin_q));
  p_empty_implies_aempty_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  p_mode_hold_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  always_comb begin
    if (!rst_n) begin
      p_reset_flags_r2: assert (!empty_n && !aempty_n);
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 256,
  parameter int AE_DEFAULT  = 7,
  parameter int AF_DEFAULT  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en1_n,
  input  logic              wr_en2_ld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              oe_n,
  output wire  [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              full_n,
  output logic              afull_n
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic [ADDR_W-1:0] waddr, raddr;
  logic              mem_we;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] ae_off, af_off, mem_rdata, q;

  dcf_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
                .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_wr (
    .wclk(wr_clk), .rst_n(rst_n), .wen1_n(wr_en1_n), .wen2_ld(wr_en2_ld),
    .wdata(wr_data), .rgray_sync(rgray_s), .waddr(waddr), .mem_we(mem_we),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n),
    .ae_off(ae_off), .af_off(af_off));

  dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk(rd_clk), .rst_n(rst_n), .ren1_n(rd_en1_n), .ren2_n(rd_en2_n),
    .ld_pin(wr_en2_ld), .wgray_sync(wgray_s), .ae_off(ae_off), .af_off(af_off),
    .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray), .q(q),
    .empty_n(empty_n), .aempty_n(aempty_n));

  dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata));

  assign rd_data = oe_n ? {DATA_W{1'bz}} : q;
endmodule

// File: tb/dcf_fifo_tb_top.sv
module dcf_fifo_tb_top;
  localparam int DW = 9;
  localparam int DP = 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic wr_en1_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  wire  [DW-1:0] rd_data;
  logic empty_n, aempty_n, full_n, afull_n;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #4 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #4 rd_clk = ~rd_clk;
  end

  dcf_fifo #(.DATA_W(DW), .DEPTH(DP)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
    .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .oe_n(oe_n), .rd_data(rd_data), .empty_n(empty_n),
    .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n));

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic strap);
    rst_n = 1'b0; wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1; wr_en2_ld = strap;
    repeat (4) @(negedge wr_clk);
    repeat (2) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    @(negedge wr_clk);
    wr_en2_ld = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic push(logic [DW-1:0] d);
    @(negedge wr_clk); wr_en1_n = 1'b0; wr_data = d;
    @(negedge wr_clk); wr_en1_n = 1'b1;
  endtask

  task automatic pop(output logic [DW-1:0] d);
    @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk); rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    d = rd_data;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    chk("R2", "empty_n in reset state", {8'h0, empty_n}, 9'h0);
    chk("R2", "aempty_n in reset state", {8'h0, aempty_n}, 9'h0);
    chk("R2", "full_n in reset state", {8'h0, full_n}, 9'h1);
    chk("R2", "afull_n in reset state", {8'h0, afull_n}, 9'h1);
  endtask

  task automatic t_dual_enable();
    logic [DW-1:0] d;
    @(negedge wr_clk); wr_en2_ld = 1'b0; wr_en1_n = 1'b0; wr_data = 9'h05A;
    @(negedge wr_clk); wr_en2_ld = 1'b1; wr_en1_n = 1'b1;
    settle();
    chk("R5", "write with second enable low stored", {8'h0, empty_n}, 9'h0);
    push(9'h0A5);
    settle();
    chk("R5", "write with both enables stored", {8'h0, empty_n}, 9'h1);
    pop(d);
    chk("R1", "single word read back", d, 9'h0A5);
  endtask

  task automatic t_fill_flags();
    logic [DW-1:0] exp_w [DP];
    logic [DW-1:0] d;
    do_reset(1'b1);
    for (int i = 0; i < DP; i++) exp_w[i] = DW'(i * 37 + 3);
    for (int i = 0; i < 7; i++) push(exp_w[i]);
    settle();
    chk("R9", "aempty_n at 7 words", {8'h0, aempty_n}, 9'h0);
    push(exp_w[7]);
    chk("R9", "afull_n at 8 words", {8'h0, afull_n}, 9'h1);
    settle();
    chk("R9", "aempty_n at 8 words", {8'h0, aempty_n}, 9'h1);
    push(exp_w[8]);
    chk("R9", "afull_n at 9 words", {8'h0, afull_n}, 9'h0);
    for (int i = 9; i < DP; i++) push(exp_w[i]);
    chk("R8", "full_n right after filling write", {8'h0, full_n}, 9'h0);
    push(9'h1FF);
    pop(d);
    chk("R1", "first word after fill", d, exp_w[0]);
    settle();
    chk("R4", "full_n released after a read", {8'h0, full_n}, 9'h1);
    for (int i = 1; i < DP; i++) begin
      pop(d);
      chk("R4", "order kept, overflow word not stored", d, exp_w[i]);
    end
    chk("R8", "empty_n right after last read", {8'h0, empty_n}, 9'h0);
  endtask

  task automatic t_read_rules();
    logic [DW-1:0] d;
    settle();
    pop(d);
    pop(d);
    push(9'h155);
    settle();
    pop(d);
    chk("R7", "read on empty did not move pointer", d, 9'h155);
    push(9'h0F0);
    push(9'h10F);
    settle();
    pop(d);
    chk("R1", "word after pointer wrap", d, 9'h0F0);
    @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b1;
    @(negedge rd_clk); rd_en1_n = 1'b1;
    chk("R7", "one read enable leaves data unchanged", rd_data, 9'h0F0);
    pop(d);
    chk("R7", "next word still waiting", d, 9'h10F);
  endtask

  task automatic t_output_enable();
    oe_n = 1'b1;
    #1;
    chk("R10", "bus released while oe_n high", {8'h0, rd_data === 9'h10F}, 9'h0);
    oe_n = 1'b0;
    #1;
    chk("R10", "bus driven while oe_n low", rd_data, 9'h10F);
  endtask

  task automatic ofs_read(output logic [DW-1:0] d);
    @(negedge rd_clk); wr_en2_ld = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk); wr_en2_ld = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    d = rd_data;
  endtask

  task automatic ofs_write(logic [DW-1:0] v);
    @(negedge wr_clk); wr_en2_ld = 1'b0; wr_en1_n = 1'b0; wr_data = v;
    @(negedge wr_clk); wr_en2_ld = 1'b1; wr_en1_n = 1'b1;
  endtask

  task automatic t_load_mode();
    logic [DW-1:0] d;
    do_reset(1'b0);
    ofs_read(d);
    chk("R11", "default almost-empty threshold", d, 9'd7);
    ofs_read(d);
    chk("R9", "default almost-full threshold", d, 9'd7);
    ofs_write(9'd6);
    ofs_write(9'd2);
    ofs_write(9'd3);
    settle();
    chk("R6", "threshold writes not stored as data", {8'h0, empty_n}, 9'h0);
    ofs_read(d);
    chk("R6", "almost-empty threshold after wrap", d, 9'd3);
    ofs_read(d);
    chk("R11", "almost-full threshold second", d, 9'd2);
    ofs_read(d);
    chk("R11", "readback order repeats", d, 9'd3);
    ofs_read(d);
    for (int i = 0; i < 3; i++) push(DW'(9'h020 + i));
    settle();
    chk("R6", "data write with first enable only", {8'h0, empty_n}, 9'h1);
    chk("R9", "aempty_n at 3 words, threshold 3", {8'h0, aempty_n}, 9'h0);
    push(9'h023);
    settle();
    chk("R9", "aempty_n at 4 words, threshold 3", {8'h0, aempty_n}, 9'h1);
    for (int i = 4; i < 13; i++) push(DW'(9'h020 + i));
    chk("R9", "afull_n at 13 words, threshold 2", {8'h0, afull_n}, 9'h1);
    push(9'h02D);
    chk("R9", "afull_n at 14 words, threshold 2", {8'h0, afull_n}, 9'h0);
    pop(d);
    chk("R3", "load-mode FIFO data intact", d, 9'h020);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_dual_enable();
    t_fill_flags();
    t_read_rules();
    t_output_enable();
    t_load_mode();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule